// File: doc/BRIEF.md
# Variable-Count 16-bit Shift and Rotate Unit

This execution unit moves a 16-bit word left or right by a count taken at the start of the instruction. It offers five operations: logical right shift, arithmetic right shift, arithmetic left shift, rotate left and rotate right. The operand is either the 16-bit accumulator pair D or two bytes in memory. It updates the four condition flags N, Z, V and C. The instruction decoder pulses `start_i` with an operation code, an addressing-mode bit, the count candidates and, for memory operands, an effective address that has already been computed.

In register mode the count comes from the immediate operand byte and the result is handed back on `result_o`, with `d_we_o` marking a D update. In indexed mode the count is the current accumulator A. The operand is read from memory and later written back through a single-outstanding byte request/acknowledge port. Shifts spend one cycle per count position. Rotates advance one bit per cycle and refresh N and Z after every step, so the count sets the execution length for every operation.

Top module: `shift16_unit`

## Requirements
- R1: The count is `imm_i` when `mode_i`=0 (register mode) and `acc_a_i` when `mode_i`=1 (indexed mode), both sampled in the cycle `start_i` is accepted. The other count input has no effect.
- R2: In indexed mode the high byte is read from `addr_i` and then the low byte from `addr_i`+1. Write-back is high byte to `addr_i` first, then low byte to `addr_i`+1.
- R3: With `op_i`=0 (logical right) or 2 (arithmetic right), count n≥1 gives `val>>n` with zero fill or sign (bit 15) fill. A count of 16 or more gives 0 or all sign bits. C is bit n−1 of the operand for n≤16 and 0 otherwise, N is result bit 15, Z is set when the result is 0, and V is unchanged. Flags are packed as {N,Z,V,C} on bits 3..0 of `ccr_i`/`ccr_o`. `op_i` values 5..7 behave as 0.
- R4: With `op_i`=3 (arithmetic left), count n≥1 gives the operand shifted left with zero fill, and 0 for n≥16. C is bit 16−n for n≤16 and 0 otherwise. V is set when bit 15 changes at any single step of the shift and is cleared otherwise. N and Z come from the result.
- R5: With `op_i`=4 (rotate left) or 1 (rotate right), the word rotates circularly by one bit per execution cycle, n times, without passing through C. After each step `result_o` and N/Z on `ccr_o` show that step's value. C and V are unchanged.
- R6: A shift (`op_i` 0, 2, 3) with count 0 leaves the value and all flags unchanged. It writes nothing: no memory write, and `d_we_o` stays low.
- R7: A rotate always writes its final value back (memory in indexed mode, `d_we_o` in register mode), even with count 0.
- R8: Execution lasts exactly n cycles. `done_o` is a one-cycle pulse. With acknowledges returned in the request cycle, `done_o` rises n cycles after the start edge in register mode. In indexed mode it rises n+4 cycles after, or 2 cycles after for a zero-count shift. `busy_o` is high from the start edge until `done_o`.
- R9: `mem_req_o` with its address, write enable and write data stays stable until `mem_ack_i`. Read data is taken in the acknowledge cycle, and wait states only delay the operation.
- R10: `start_i` is ignored while `busy_o` is high.
- R11: After reset `busy_o`, `done_o`, `d_we_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| op_i | input | 3 | 0 LSR, 1 ROR, 2 ASR, 3 ASL, 4 ROL |
| mode_i | input | 1 | 0 register operand, 1 memory operand |
| imm_i | input | CW (8) | Count for register mode |
| acc_a_i | input | CW (8) | Accumulator A, count for indexed mode |
| acc_d_i | input | DW (16) | Accumulator pair D, register-mode operand |
| addr_i | input | AW (16) | Effective address of the memory operand |
| ccr_i | input | 4 | Incoming flags {N,Z,V,C} |
| mem_req_o | output | 1 | Byte access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW (16) | Byte address |
| mem_wdata_o | output | DW/2 (8) | Write byte |
| mem_rdata_i | input | DW/2 (8) | Read byte, valid with acknowledge |
| mem_ack_i | input | 1 | Access completes this cycle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| d_we_o | output | 1 | Write `result_o` to D (with `done_o`) |
| result_o | output | DW (16) | Working / final value |
| ccr_o | output | 4 | Working / final flags {N,Z,V,C} |

## Verification
The bench builds the unit with its defaults: a 16-bit word, an 8-bit count and a 16-bit address. The 8-bit count lets it drive counts well past the word width (16, 17, 20), so the saturating shift results, the out-of-word carry positions and full-circle rotates are all exercised, along with the one-cycle-per-count timing. The same vectors run in both addressing modes, with the unused count input deliberately mismatched. Acknowledge stalls and a start during busy probe the byte handshake and the start guard.

// File: rtl/shift16_pkg.sv
package shift16_pkg;
  typedef enum logic [2:0] {
    OP_LSR = 3'd0,
    OP_ROR = 3'd1,
    OP_ASR = 3'd2,
    OP_ASL = 3'd3,
    OP_ROL = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_HI, ST_RD_LO, ST_EXEC, ST_WR_HI, ST_WR_LO, ST_FIN
  } st_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/shift16_barrel.sv
module shift16_barrel import shift16_pkg::*; #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 8
) (
  input  logic [DW-1:0] val_i,
  input  logic [CW-1:0] cnt_i,
  input  op_e           op_i,
  input  ccr_t          ccr_i,
  output logic [DW-1:0] res_o,
  output ccr_t          ccr_o
);
  localparam int unsigned SW = $clog2(DW);

  logic          big;
  logic          in_word;
  logic [SW-1:0] sh;
  logic [CW-1:0] r_idx;
  logic [CW-1:0] l_idx;
  logic          v_chg;

  assign big     = cnt_i >= CW'(DW);
  assign in_word = (cnt_i != '0) && (cnt_i <= CW'(DW));
  assign sh      = big ? '0 : cnt_i[SW-1:0];
  assign r_idx   = cnt_i - CW'(1);
  assign l_idx   = CW'(DW) - cnt_i;

  // sign of bit DW-1 changes at some step of the left shift
  always_comb begin
    v_chg = 1'b0;
    if (big) v_chg = |val_i;
    else
      for (int k = 1; k < DW; k++)
        if ((k <= int'(cnt_i)) && (val_i[DW-1-k] != val_i[DW-1])) v_chg = 1'b1;
  end

  always_comb begin
    res_o = val_i;
    ccr_o = ccr_i;
    if (cnt_i != '0) begin
      unique case (op_i)
        OP_ASR: begin
          res_o   = big ? {DW{val_i[DW-1]}} : DW'($signed(val_i) >>> sh);
          ccr_o.c = in_word ? val_i[r_idx[SW-1:0]] : 1'b0;
        end
        OP_ASL: begin
          res_o   = big ? '0 : (val_i << sh);
          ccr_o.c = in_word ? val_i[l_idx[SW-1:0]] : 1'b0;
          ccr_o.v = v_chg;
        end
        default: begin
          res_o   = big ? '0 : (val_i >> sh);
          ccr_o.c = in_word ? val_i[r_idx[SW-1:0]] : 1'b0;
        end
      endcase
      ccr_o.n = res_o[DW-1];
      ccr_o.z = (res_o == '0);
    end
  end
endmodule

// File: rtl/shift16_ctrl.sv
module shift16_ctrl import shift16_pkg::*; #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          ind_q_i,
  input  logic          rot_q_i,
  input  logic          mem_ack_i,
  output st_e           st_o,
  output logic          accept_o,
  output logic          first_o,
  output logic          done_o,
  output logic          busy_o
);
  st_e           st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic          first_q;

  assign accept_o = (st_q == ST_IDLE) && start_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = mode_i ? ST_RD_HI : ((cnt_i == '0) ? ST_FIN : ST_EXEC);
      ST_RD_HI: if (mem_ack_i) st_d = ST_RD_LO;
      ST_RD_LO: if (mem_ack_i)
                  st_d = (cnt_q != '0) ? ST_EXEC : (rot_q_i ? ST_WR_HI : ST_FIN);
      ST_EXEC:  if (cnt_q == CW'(1)) st_d = ind_q_i ? ST_WR_HI : ST_FIN;
      ST_WR_HI: if (mem_ack_i) st_d = ST_WR_LO;
      ST_WR_LO: if (mem_ack_i) st_d = ST_FIN;
      ST_FIN:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      first_q <= (st_d == ST_EXEC) && (st_q != ST_EXEC);
      if (accept_o) cnt_q <= cnt_i;
      else if (st_q == ST_EXEC) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign st_o    = st_q;
  assign first_o = first_q;
  assign done_o  = (st_q == ST_FIN);
  assign busy_o  = (st_q != ST_IDLE) && (st_q != ST_FIN);
endmodule

// File: rtl/shift16_unit.sv
module shift16_unit import shift16_pkg::*; #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 8,
  parameter int unsigned AW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2:0]      op_i,
  input  logic            mode_i,
  input  logic [CW-1:0]   imm_i,
  input  logic [CW-1:0]   acc_a_i,
  input  logic [DW-1:0]   acc_d_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [3:0]      ccr_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW/2-1:0] mem_wdata_o,
  input  logic [DW/2-1:0] mem_rdata_i,
  input  logic            mem_ack_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            d_we_o,
  output logic [DW-1:0]   result_o,
  output logic [3:0]      ccr_o
);
  localparam int unsigned BW = DW / 2;

  st_e           st;
  logic          accept, first;
  logic [CW-1:0] cnt_sel;
  op_e           op_q;
  logic          ind_q, nz_q;
  logic [CW-1:0] n_q;
  logic [DW-1:0] val_q;
  ccr_t          ccr_q;
  logic [AW-1:0] ea_q;
  logic          rot_q, rol_q, rot_step;
  logic [DW-1:0] bar_res, rot_val;
  ccr_t          bar_ccr;

  assign cnt_sel  = mode_i ? acc_a_i : imm_i;
  assign rot_q    = (op_q == OP_ROL) || (op_q == OP_ROR);
  assign rol_q    = (op_q == OP_ROL);
  assign rot_step = (st == ST_EXEC) && rot_q;
  assign rot_val  = rol_q ? {val_q[DW-2:0], val_q[DW-1]} : {val_q[0], val_q[DW-1:1]};

  shift16_ctrl #(.CW(CW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .cnt_i    (cnt_sel),
    .ind_q_i  (ind_q),
    .rot_q_i  (rot_q),
    .mem_ack_i(mem_ack_i),
    .st_o     (st),
    .accept_o (accept),
    .first_o  (first),
    .done_o   (done_o),
    .busy_o   (busy_o)
  );

  shift16_barrel #(.DW(DW), .CW(CW)) u_barrel (
    .val_i(val_q),
    .cnt_i(n_q),
    .op_i (op_q),
    .ccr_i(ccr_q),
    .res_o(bar_res),
    .ccr_o(bar_ccr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_LSR;
      ind_q <= 1'b0;
      nz_q  <= 1'b0;
      n_q   <= '0;
      val_q <= '0;
      ccr_q <= '0;
      ea_q  <= '0;
    end else if (accept) begin
      op_q  <= (op_i > 3'd4) ? OP_LSR : op_e'(op_i);
      ind_q <= mode_i;
      nz_q  <= (cnt_sel != '0);
      n_q   <= cnt_sel;
      val_q <= acc_d_i;
      ccr_q <= ccr_t'(ccr_i);
      ea_q  <= addr_i;
    end else begin
      unique case (st)
        ST_RD_HI: if (mem_ack_i) val_q[DW-1:BW] <= mem_rdata_i;
        ST_RD_LO: if (mem_ack_i) val_q[BW-1:0]  <= mem_rdata_i;
        ST_EXEC: begin
          if (rot_q) begin
            val_q   <= rot_val;
            ccr_q.n <= rot_val[DW-1];
            ccr_q.z <= (rot_val == '0);
          end else if (first) begin
            val_q <= bar_res;
            ccr_q <= bar_ccr;
          end
        end
        default: ;
      endcase
    end
  end

  assign mem_req_o   = (st == ST_RD_HI) || (st == ST_RD_LO) || (st == ST_WR_HI) || (st == ST_WR_LO);
  assign mem_we_o    = (st == ST_WR_HI) || (st == ST_WR_LO);
  assign mem_addr_o  = ((st == ST_RD_LO) || (st == ST_WR_LO)) ? ea_q + AW'(1) : ea_q;
  assign mem_wdata_o = (st == ST_WR_HI) ? val_q[DW-1:BW] : val_q[BW-1:0];
  assign d_we_o      = done_o && !ind_q && (nz_q || rot_q);
  assign result_o    = val_q;
  assign ccr_o       = ccr_q;
endmodule

// File: rtl/shift16_chk.sv
module shift16_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 8,
  parameter int unsigned AW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            done_o,
  input logic            d_we_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic            mem_ack_i,
  input logic [AW-1:0]   mem_addr_o,
  input logic [DW/2-1:0] mem_wdata_o,
  input logic [DW-1:0]   result_o,
  input logic            rot_step,
  input logic            rol_q,
  input logic            rot_q,
  input logic            nz_q,
  input logic [CW-1:0]   n_q,
  input logic [AW-1:0]   ea_q
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o)); // R9
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o); // R9
  AST_ROT_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rot_step |=> result_o == ($past(rol_q)
      ? DW'(($past(result_o) << 1) | ($past(result_o) >> (DW-1)))
      : DW'(($past(result_o) >> 1) | ($past(result_o) << (DW-1))))); // R5
  AST_ZERO_SHIFT_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || d_we_o) |-> (nz_q || rot_q)); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(n_q) && $stable(ea_q)); // R10
endmodule

bind shift16_unit shift16_chk #(.DW(DW), .CW(CW), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .d_we_o     (d_we_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_ack_i  (mem_ack_i),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .result_o   (result_o),
  .rot_step   (rot_step),
  .rol_q      (rol_q),
  .rot_q      (rot_q),
  .nz_q       (nz_q),
  .n_q        (n_q),
  .ea_q       (ea_q)
);

// File: tb/shift16_unit_tb.sv
module shift16_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] EA = 16'h0040;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  n;
    logic [15:0] v;
    logic [3:0]  fi;
    logic [15:0] r;
    logic [3:0]  fo;
  } vec_t;

  // op, count, operand, flags in, result, flags out ({N,Z,V,C})
  localparam vec_t VEC [12] = '{
    {3'd0, 8'd1,  16'h8421, 4'b0010, 16'h4210, 4'b0011},
    {3'd2, 8'd4,  16'h8421, 4'b0000, 16'hF842, 4'b1000},
    {3'd3, 8'd1,  16'h4001, 4'b0000, 16'h8002, 4'b1010},
    {3'd3, 8'd2,  16'hC000, 4'b0000, 16'h0000, 4'b0111},
    {3'd4, 8'd4,  16'h1234, 4'b0011, 16'h2341, 4'b0011},
    {3'd1, 8'd8,  16'h00FF, 4'b0100, 16'hFF00, 4'b1000},
    {3'd0, 8'd16, 16'hFFFF, 4'b0000, 16'h0000, 4'b0101},
    {3'd2, 8'd20, 16'h8000, 4'b0001, 16'hFFFF, 4'b1000},
    {3'd3, 8'd17, 16'h0001, 4'b0000, 16'h0000, 4'b0110},
    {3'd4, 8'd16, 16'hA5A5, 4'b0100, 16'hA5A5, 4'b1000},
    {3'd3, 8'd3,  16'h1FFF, 4'b1111, 16'hFFF8, 4'b1010},
    {3'd3, 8'd1,  16'hFFFF, 4'b0000, 16'hFFFE, 4'b1001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic        mode = 1'b0;
  logic [7:0]  imm = '0, acc_a = '0;
  logic [15:0] acc_d = '0, addr = EA;
  logic [3:0]  ccr_in = '0;
  logic        mem_req, mem_we, mem_ack, busy, done, d_we;
  logic [15:0] mem_addr, result;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [3:0]  ccr_out;
  logic        stall = 1'b0, stall_en = 1'b0;
  logic [7:0]  mem [0:255];
  int          wr_cnt = 0, done_cnt = 0, cyc = 0;
  int          total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift16_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .mode_i(mode),
    .imm_i(imm), .acc_a_i(acc_a), .acc_d_i(acc_d), .addr_i(addr), .ccr_i(ccr_in),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .busy_o(busy), .done_o(done), .d_we_o(d_we), .result_o(result), .ccr_o(ccr_out)
  );

  assign mem_ack   = mem_req && !stall;
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (mem_req && mem_we && mem_ack) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  always @(negedge clk) stall <= stall_en && (cyc % 3 != 0);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] o);
    if (o == 3'd3) return "R4";
    if (o == 3'd1 || o == 3'd4) return "R5";
    return "R3";
  endfunction

  // launch one operation; the unused count input gets a different value (R1)
  task automatic run_op(input logic [2:0] o, input logic m, input logic [7:0] n,
                        input logic [15:0] v, input logic [3:0] fi, output int lat);
    @(negedge clk);
    while (busy || done) @(negedge clk);
    op = o; mode = m; ccr_in = fi;
    if (m) begin
      mem[EA[7:0]] = v[15:8]; mem[EA[7:0]+1] = v[7:0];
      acc_a = n; imm = ~n; acc_d = 16'h5A5A;
    end else begin
      acc_d = v; imm = n; acc_a = ~n;
    end
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    lat = 0;
    while (!done && lat < 2000) begin
      @(posedge clk); #1;
      lat++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat, w0, d0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "busy", busy, 0);
    chk("R11", "done", done, 0);
    chk("R11", "d_we", d_we, 0);
    chk("R11", "mem_req", mem_req, 0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      // register mode, count from imm (R1)
      run_op(VEC[i].op, 1'b0, VEC[i].n, VEC[i].v, VEC[i].fi, lat);
      chk({"R1 ", req_of(VEC[i].op)}, $sformatf("reg result v%0d", i), result, VEC[i].r);
      chk(req_of(VEC[i].op), $sformatf("reg flags v%0d", i), ccr_out, VEC[i].fo);
      chk("R8", $sformatf("reg latency v%0d", i), lat, VEC[i].n);
      chk("R7", $sformatf("reg d_we v%0d", i), d_we, 1);
      // indexed mode, count from A, operand in memory (R1 R2)
      w0 = wr_cnt;
      run_op(VEC[i].op, 1'b1, VEC[i].n, VEC[i].v, VEC[i].fi, lat);
      #1;
      chk({"R2 ", req_of(VEC[i].op)}, $sformatf("mem result v%0d", i),
          {mem[EA[7:0]], mem[EA[7:0]+1]}, VEC[i].r);
      chk(req_of(VEC[i].op), $sformatf("ind flags v%0d", i), ccr_out, VEC[i].fo);
      chk("R8", $sformatf("ind latency v%0d", i), lat, VEC[i].n + 4);
      chk("R2", $sformatf("ind writes v%0d", i), wr_cnt - w0, 2);
      chk("R1", $sformatf("ind d_we v%0d", i), d_we, 0);
    end

    // R6 zero-count shift, register mode
    run_op(3'd0, 1'b0, 8'd0, 16'h8001, 4'b1011, lat);
    chk("R6", "zero lsr result", result, 16'h8001);
    chk("R6", "zero lsr flags", ccr_out, 4'b1011);
    chk("R6", "zero lsr d_we", d_we, 0);
    chk("R8", "zero lsr latency", lat, 0);

    // R6 zero-count shift, indexed: no writes
    w0 = wr_cnt;
    run_op(3'd3, 1'b1, 8'd0, 16'hC3A5, 4'b0110, lat);
    #1;
    chk("R6", "zero asl writes", wr_cnt - w0, 0);
    chk("R6", "zero asl flags", ccr_out, 4'b0110);
    chk("R6", "zero asl mem", {mem[EA[7:0]], mem[EA[7:0]+1]}, 16'hC3A5);
    chk("R8", "zero asl latency", lat, 2);

    // R7 zero-count rotate still writes back
    w0 = wr_cnt;
    run_op(3'd1, 1'b1, 8'd0, 16'h1357, 4'b1001, lat);
    #1;
    chk("R7", "zero ror writes", wr_cnt - w0, 2);
    chk("R7", "zero ror mem", {mem[EA[7:0]], mem[EA[7:0]+1]}, 16'h1357);
    chk("R7", "zero ror flags", ccr_out, 4'b1001);
    chk("R8", "zero ror latency", lat, 4);
    run_op(3'd4, 1'b0, 8'd0, 16'h2468, 4'b0000, lat);
    chk("R7", "zero rol d_we", d_we, 1);

    // R5 per-step rotate: ROL 0x8000 by 3, N set on entry
    @(negedge clk);
    while (busy || done) @(negedge clk);
    op = 3'd4; mode = 1'b0; imm = 8'd3; acc_a = 8'd9; acc_d = 16'h8000; ccr_in = 4'b1000;
    start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    @(posedge clk); #1;
    chk("R5", "rol step1 value", result, 16'h0001);
    chk("R5", "rol step1 N", ccr_out[3], 0);
    @(posedge clk); #1;
    chk("R5", "rol step2 value", result, 16'h0002);
    @(posedge clk); #1;
    chk("R5", "rol step3 value", result, 16'h0004);
    chk("R8", "rol done", done, 1);

    // R9 wait states on the memory port
    stall_en = 1'b1;
    run_op(3'd2, 1'b1, 8'd2, 16'h8F00, 4'b0000, lat);
    stall_en = 1'b0;
    #1;
    chk("R9", "stalled mem result", {mem[EA[7:0]], mem[EA[7:0]+1]}, 16'hE3C0);
    chk("R9", "stalled flags", ccr_out, 4'b1000);
    chk("R9", "stalled latency longer", lat > 6, 1);

    // R10 start while busy is ignored
    @(negedge clk);
    while (busy || done) @(negedge clk);
    mem[EA[7:0]] = 8'h80; mem[EA[7:0]+1] = 8'h00;
    op = 3'd0; mode = 1'b1; acc_a = 8'd3; imm = 8'd0; ccr_in = 4'b0000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    op = 3'd3; mode = 1'b0; imm = 8'd1; acc_d = 16'h0001; addr = 16'h0080;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; addr = EA;
    d0 = done_cnt;
    while (!done) @(negedge clk);
    chk("R10", "mem after busy start", {mem[EA[7:0]], mem[EA[7:0]+1]}, 16'h1000);
    chk("R10", "d_we after busy start", d_we, 0);
    repeat (4) @(negedge clk);
    chk("R10", "single done", done_cnt - d0, 1);
    chk("R10", "idle after", busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule